// File: doc/BRIEF.md
# Static RAM Burst Controller with Speed-Dependent Beat Timing

This block lets a synchronous processor bus reach an asynchronous static RAM. At reset it captures a window base address and a window size code from an options input. From then on it claims any request whose address falls inside that window. For a claimed request it drives chip-select, output-enable and write-enable to the memory together with a byte address relative to the window base. It also raises a one-clock acknowledge at the end of every data beat.

Burst requests carry four beats and single requests carry one. The number of clocks in each beat is a fixed schedule, sized for 100 ns memory parts. It is chosen by a bus-speed select input (slow or fast clock) and by the transfer direction. The first beat is always longer than the beats after it. Within a burst the word address steps through the 16-byte line and wraps back to the start of the line.

Top module: `sram_burst_ctrl`

## Requirements
- R1: While `rst_n` is low, the window base is loaded from `cfg_base` and the size code from `cfg_size_code`. After reset is released, changes on these inputs have no effect on which addresses are claimed.
- R2: A request is claimed when (`bus_addr` − base) modulo 2^32 is below the window size. The size is 128 KB << code for codes 0 to 4, and codes 5 to 7 select 2 MB. An unclaimed request produces no acknowledge, and chip-select stays high.
- R3: With `speed_fast` = 0, the first beat of both reads and writes lasts 5 clocks and each later beat lasts 3 clocks.
- R4: With `speed_fast` = 1, the first beat of a read lasts 6 clocks and each later beat lasts 4 clocks.
- R5: With `speed_fast` = 1, the first beat of a write lasts 6 clocks and each later beat lasts 3 clocks.
- R6: A request is accepted on a rising edge where `bus_req` is high and the address is claimed. The first beat occupies the next N clocks. `bus_ack` is high for exactly the last clock of each beat. A burst (`bus_burst` = 1) gives four acknowledges. A single request gives one acknowledge, using the first-beat timing. Chip-select rises in the clock after the final acknowledge.
- R7: `sram_ce_n` is low on every clock of an access. `sram_oe_n` is low on every clock of a read. On a write, `sram_we_n` is low on every clock of each beat except the first and last clocks of that beat. The output-enable and write-enable strobes are never low together.
- R8: `sram_addr` is the request address minus the base, with bits [1:0] zero. Bits [3:2] start at the request's word index and advance by one per beat modulo 4. Bits [20:4] are held for the whole access.
- R9: A request that arrives while an access is in progress is ignored. It neither extends the access nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the window configuration |
| cfg_base | input | 32 | Window base address captured during reset |
| cfg_size_code | input | 3 | Window size code captured during reset (128 KB << code, 5 to 7 mean 2 MB) |
| bus_req | input | 1 | Request strobe, sampled on the rising edge |
| bus_addr | input | 32 | Byte address of the request (word aligned) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| speed_fast | input | 1 | 1 = fast bus clock schedule, 0 = slow |
| sram_ce_n | output | 1 | Memory chip-select, active low |
| sram_oe_n | output | 1 | Memory output-enable, active low |
| sram_we_n | output | 1 | Memory write-enable, active low |
| sram_addr | output | 21 | Byte address within the window |
| bus_ack | output | 1 | Per-beat transfer acknowledge, one clock wide |

## Verification
Some properties are checked on every clock: the one-clock width of the acknowledge, the exclusivity of the two enables and their cover by chip-select, the line-wrapping step of the address between beats, the release of chip-select after the last beat, and that the captured window holds after reset. Other behaviour only the bench scenarios can show: the exact beat lengths for each speed and direction, window hit and miss at both edges and under the size-code clamp, that configuration changes after reset are ignored, and that a request arriving mid-burst is dropped.

// File: rtl/sbc_pkg.sv
// Package: shared types for the static RAM burst controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sbc_pkg;

    // Attributes of one access, latched at acceptance.
    typedef struct packed {
        logic write;
        logic burst;
        logic fast;
    } sbc_xfer_t;

endpackage

// File: rtl/sbc_window.sv
// Module: sbc_window
// Holds the window base and size code captured during reset. Decodes whether
// a bus address falls in the window and gives its offset from the base.
// Assumes: the size is a power of two between 2^MIN_SIZE_LOG and
// 2^MAX_SIZE_LOG; codes beyond the top are clamped to the largest size.
module sbc_window #(
    parameter int AW           = 32,
    parameter int SRAM_AW      = 21,
    parameter int CODE_W       = 3,
    parameter int MIN_SIZE_LOG = 17,
    parameter int MAX_SIZE_LOG = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      cfg_base,
    input  logic [CODE_W-1:0]  cfg_size_code,
    input  logic [AW-1:0]      addr,
    output logic               hit,
    output logic [SRAM_AW-1:0] offset
);
    localparam int MAX_CODE = MAX_SIZE_LOG - MIN_SIZE_LOG;

    logic [AW-1:0]     base_q;
    logic [CODE_W-1:0] code_q;
    logic [7:0]        size_log;
    logic [AW-1:0]     size_bytes;
    logic [AW-1:0]     diff;

    // Capture the configuration while reset is held; hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= cfg_base;
            code_q <= cfg_size_code;
        end
    end

    // Turn the size code into a byte count, clamped at the largest size.
    always_comb begin
        if (int'(code_q) > MAX_CODE)
            size_log = 8'(MAX_SIZE_LOG);
        else
            size_log = 8'(MIN_SIZE_LOG) + 8'(code_q);
        size_bytes = AW'(1) << size_log;
    end

    // Window hit by unsigned distance from the base.
    always_comb begin
        diff   = addr - base_q;
        hit    = diff < size_bytes;
        offset = diff[SRAM_AW-1:0];
    end

    // After reset the captured window never changes.
    assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(base_q) && $stable(code_q)));

endmodule

// File: rtl/sbc_timing.sv
// Module: sbc_timing
// Gives the clock count of the current beat from the speed select, the
// direction and whether it is the first beat.
// Assumes: every count is at least 3, so a write beat has a middle clock.
module sbc_timing #(
    parameter int CNT_W          = 3,
    parameter int SLOW_FIRST     = 5,
    parameter int SLOW_NEXT      = 3,
    parameter int FAST_RD_FIRST  = 6,
    parameter int FAST_RD_NEXT   = 4,
    parameter int FAST_WR_FIRST  = 6,
    parameter int FAST_WR_NEXT   = 3
) (
    input  logic             fast,
    input  logic             write,
    input  logic             first_beat,
    output logic [CNT_W-1:0] beat_len
);
    // Select the beat length from the schedule table.
    always_comb begin
        if (!fast)
            beat_len = first_beat ? CNT_W'(SLOW_FIRST) : CNT_W'(SLOW_NEXT);
        else if (write)
            beat_len = first_beat ? CNT_W'(FAST_WR_FIRST) : CNT_W'(FAST_WR_NEXT);
        else
            beat_len = first_beat ? CNT_W'(FAST_RD_FIRST) : CNT_W'(FAST_RD_NEXT);
    end

endmodule

// File: rtl/sbc_sequencer.sv
// Module: sbc_sequencer
// Runs one access: counts clocks within each beat, steps the beat number,
// and drives the memory strobes, the wrapped address and the acknowledge.
// Assumes: BEATS is a power of two; starts are ignored while busy.
module sbc_sequencer
    import sbc_pkg::*;
#(
    parameter int SRAM_AW = 21,
    parameter int BEATS   = 4,
    parameter int CNT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  sbc_xfer_t          start_xfer,
    input  logic [SRAM_AW-1:2] start_offset,
    input  logic [CNT_W-1:0]   beat_len,
    output sbc_xfer_t          cur_xfer,
    output logic               first_beat,
    output logic               sram_ce_n,
    output logic               sram_oe_n,
    output logic               sram_we_n,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               bus_ack
);
    localparam int WORD_W   = $clog2(BEATS);
    localparam int LINE_LSB = WORD_W + 2;

    logic                      active_q;
    logic [CNT_W-1:0]          cnt_q;
    logic [WORD_W-1:0]         beat_q;
    logic [WORD_W-1:0]         word_q;
    logic [SRAM_AW-1:LINE_LSB] line_q;
    sbc_xfer_t                 xfer_q;
    logic                      beat_end;
    logic                      last_beat;

    // End-of-beat and end-of-access conditions.
    always_comb begin
        beat_end  = active_q && (cnt_q == CNT_W'(beat_len - CNT_W'(1)));
        last_beat = !xfer_q.burst || (beat_q == WORD_W'(BEATS - 1));
    end

    // Access state: accept when idle, count clocks, step beats, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            beat_q   <= '0;
            word_q   <= '0;
            line_q   <= '0;
            xfer_q   <= '0;
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                beat_q   <= '0;
                xfer_q   <= start_xfer;
                line_q   <= start_offset[SRAM_AW-1:LINE_LSB];
                word_q   <= start_offset[LINE_LSB-1:2];
            end
        end else if (beat_end) begin
            cnt_q <= '0;
            if (last_beat)
                active_q <= 1'b0;
            else
                beat_q <= beat_q + WORD_W'(1);
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Memory strobes, wrapped address and acknowledge.
    always_comb begin
        cur_xfer   = xfer_q;
        first_beat = (beat_q == '0);
        sram_ce_n  = !active_q;
        sram_oe_n  = !(active_q && !xfer_q.write);
        sram_we_n  = !(active_q && xfer_q.write && (cnt_q != '0) && !beat_end);
        sram_addr  = {line_q, WORD_W'(word_q + beat_q), 2'b00};
        bus_ack    = beat_end;
    end

    // Acknowledge lasts one clock.
    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // Chip-select rises after the final acknowledge.
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && last_beat) |=> sram_ce_n);

    // Output and write enables never overlap.
    assert_enable_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    // Any enable is covered by chip-select.
    assert_ce_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n || !sram_we_n) |-> !sram_ce_n);

    // Between beats the line is held and the word index steps by one.
    assert_line_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !last_beat) |=>
            (sram_addr[SRAM_AW-1:LINE_LSB] == $past(sram_addr[SRAM_AW-1:LINE_LSB])) &&
            (sram_addr[LINE_LSB-1:2] == WORD_W'($past(sram_addr[LINE_LSB-1:2]) + WORD_W'(1))));

endmodule

// File: rtl/sram_burst_ctrl.sv
// Module: sram_burst_ctrl (top)
// Static RAM controller on a synchronous bus: window decode from reset-time
// configuration, per-beat timing by speed and direction, and the sequencer.
// Assumes: word-aligned requests; a request is a one-clock strobe.
module sram_burst_ctrl
    import sbc_pkg::*;
#(
    parameter int AW            = 32,
    parameter int SRAM_AW       = 21,
    parameter int CODE_W        = 3,
    parameter int MIN_SIZE_LOG  = 17,
    parameter int BEATS         = 4,
    parameter int SLOW_FIRST    = 5,
    parameter int SLOW_NEXT     = 3,
    parameter int FAST_RD_FIRST = 6,
    parameter int FAST_RD_NEXT  = 4,
    parameter int FAST_WR_FIRST = 6,
    parameter int FAST_WR_NEXT  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      cfg_base,
    input  logic [CODE_W-1:0]  cfg_size_code,
    input  logic               bus_req,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_write,
    input  logic               bus_burst,
    input  logic               speed_fast,
    output logic               sram_ce_n,
    output logic               sram_oe_n,
    output logic               sram_we_n,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               bus_ack
);
    localparam int MAX_FIRST = (SLOW_FIRST > FAST_RD_FIRST) ?
        ((SLOW_FIRST > FAST_WR_FIRST) ? SLOW_FIRST : FAST_WR_FIRST) :
        ((FAST_RD_FIRST > FAST_WR_FIRST) ? FAST_RD_FIRST : FAST_WR_FIRST);
    localparam int MAX_NEXT = (SLOW_NEXT > FAST_RD_NEXT) ?
        ((SLOW_NEXT > FAST_WR_NEXT) ? SLOW_NEXT : FAST_WR_NEXT) :
        ((FAST_RD_NEXT > FAST_WR_NEXT) ? FAST_RD_NEXT : FAST_WR_NEXT);
    localparam int MAX_LEN = (MAX_FIRST > MAX_NEXT) ? MAX_FIRST : MAX_NEXT;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic               hit;
    logic [SRAM_AW-1:0] offset;
    logic [CNT_W-1:0]   beat_len;
    logic               first_beat;
    sbc_xfer_t          req_xfer;
    sbc_xfer_t          cur_xfer;

    // Pack the request attributes.
    always_comb begin
        req_xfer.write = bus_write;
        req_xfer.burst = bus_burst;
        req_xfer.fast  = speed_fast;
    end

    sbc_window #(
        .AW(AW), .SRAM_AW(SRAM_AW), .CODE_W(CODE_W),
        .MIN_SIZE_LOG(MIN_SIZE_LOG), .MAX_SIZE_LOG(SRAM_AW)
    ) u_window (
        .clk(clk), .rst_n(rst_n),
        .cfg_base(cfg_base), .cfg_size_code(cfg_size_code),
        .addr(bus_addr), .hit(hit), .offset(offset)
    );

    sbc_timing #(
        .CNT_W(CNT_W),
        .SLOW_FIRST(SLOW_FIRST), .SLOW_NEXT(SLOW_NEXT),
        .FAST_RD_FIRST(FAST_RD_FIRST), .FAST_RD_NEXT(FAST_RD_NEXT),
        .FAST_WR_FIRST(FAST_WR_FIRST), .FAST_WR_NEXT(FAST_WR_NEXT)
    ) u_timing (
        .fast(cur_xfer.fast), .write(cur_xfer.write),
        .first_beat(first_beat), .beat_len(beat_len)
    );

    sbc_sequencer #(
        .SRAM_AW(SRAM_AW), .BEATS(BEATS), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(bus_req && hit), .start_xfer(req_xfer),
        .start_offset(offset[SRAM_AW-1:2]), .beat_len(beat_len),
        .cur_xfer(cur_xfer), .first_beat(first_beat),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_addr(sram_addr), .bus_ack(bus_ack)
    );

    // A miss while idle never raises chip-select in the next clock.
    assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_ce_n && bus_req && !hit) |=> sram_ce_n);

endmodule

// File: tb/tb_sram_burst_ctrl.sv
// Bench: vector table of accesses, then directed reset and corner cases.
module tb_sram_burst_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = 32'h0040_0000;
    logic [2:0]  cfg_size_code = 3'd2;
    logic        bus_req = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic        bus_burst = 1'b0;
    logic        speed_fast = 1'b0;
    logic        sram_ce_n, sram_oe_n, sram_we_n, bus_ack;
    logic [20:0] sram_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] cur_base = 32'h0040_0000;

    always #4 clk = ~clk;

    sram_burst_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size_code(cfg_size_code),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_burst(bus_burst), .speed_fast(speed_fast),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_addr(sram_addr), .bus_ack(bus_ack)
    );

    // Vector: {addr[31:0], write, burst, fast, hit, re_request}
    localparam int NV = 9;
    localparam logic [36:0] VEC [NV] = '{
        {32'h0040_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {32'h0040_0004, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {32'h0040_000C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {32'h0040_0008, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {32'h0047_FFF8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {32'h0040_0010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {32'h0048_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {32'h003F_FFFC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {32'h0041_2344, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected beat length from R3, R4, R5.
    function automatic int beat_len(bit fast, bit wr, bit first);
        if (!fast) return first ? 5 : 3;
        if (wr)    return first ? 6 : 3;
        return first ? 6 : 4;
    endfunction

    task automatic do_reset(input logic [31:0] base, input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0; cfg_base = base; cfg_size_code = code; bus_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_base = base;
    endtask

    // One access from a negedge; samples every following negedge.
    task automatic run_access(input logic [31:0] addr, input bit wr, input bit burst,
                              input bit fast, input bit hit, input bit rereq, input string tag);
        int nbeats = burst ? 4 : 1;
        int total = hit ? beat_len(fast, wr, 1) + (nbeats - 1) * beat_len(fast, wr, 0) : 0;
        int b = 0;
        int pos = 0;
        bit ack_ok = 1, str_ok = 1, adr_ok = 1, idle_ok = 1;
        logic [63:0] ack_a = 0, ack_e = 0, str_a = 0, str_e = 0, adr_a = 0, adr_e = 0;
        logic [31:0] off = addr - cur_base;
        @(negedge clk);
        bus_req = 1'b1; bus_addr = addr; bus_write = wr; bus_burst = burst; speed_fast = fast;
        @(negedge clk);
        bus_req = 1'b0;
        for (int k = 1; k <= total + 3; k++) begin
            if (rereq && k == 3) begin bus_req = 1'b1; bus_addr = cur_base + 32'h40; end
            if (rereq && k == 4) bus_req = 1'b0;
            if (k <= total) begin
                int len = beat_len(fast, wr, b == 0);
                bit e_ack = (pos == len - 1);
                bit e_we = !(wr && pos != 0 && pos != len - 1);
                logic [20:0] e_adr = {off[20:4], 2'(off[3:2] + 2'(b)), 2'b00};
                if (bus_ack !== e_ack && ack_ok) begin
                    ack_ok = 0; ack_a = {32'(k), 31'd0, bus_ack}; ack_e = {32'(k), 31'd0, e_ack};
                end
                if ({sram_ce_n, sram_oe_n, sram_we_n} !== {1'b0, wr, e_we} && str_ok) begin
                    str_ok = 0; str_a = {32'(k), 29'd0, sram_ce_n, sram_oe_n, sram_we_n};
                    str_e = {32'(k), 29'd0, 1'b0, wr, e_we};
                end
                if (sram_addr !== e_adr && adr_ok) begin
                    adr_ok = 0; adr_a = {32'(k), 11'd0, sram_addr}; adr_e = {32'(k), 11'd0, e_adr};
                end
                if (e_ack) begin pos = 0; b++; end else pos++;
            end else begin
                if ((sram_ce_n !== 1'b1 || bus_ack !== 1'b0) && idle_ok) begin
                    idle_ok = 0; str_a = {32'(k), 30'd0, sram_ce_n, bus_ack};
                end
            end
            @(negedge clk);
        end
        if (hit) begin
            check(ack_ok, {"R6 ack timing (R3 R4 R5) ", tag}, ack_a, ack_e);
            check(str_ok, {"R7 strobes ", tag}, str_a, str_e);
            check(adr_ok, {"R8 address ", tag}, adr_a, adr_e);
            check(idle_ok, {rereq ? "R9 ignored re-request " : "R6 idle after ", tag}, str_a, 64'h2);
        end else begin
            check(idle_ok, {"R2 miss stays quiet ", tag}, str_a, 64'h2);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset(32'h0040_0000, 3'd2);
        #1;
        check({sram_ce_n, sram_oe_n, sram_we_n, bus_ack} === 4'b1110, "R6 reset idle",
              {sram_ce_n, sram_oe_n, sram_we_n, bus_ack}, 64'he);

        for (int i = 0; i < NV; i++) begin
            logic [36:0] v = VEC[i];
            run_access(v[36:5], v[4], v[3], v[2], v[1], v[0], $sformatf("vec%0d", i));
        end

        // R1: configuration changes after reset are ignored.
        @(negedge clk);
        cfg_base = 32'h0100_0000; cfg_size_code = 3'd4;
        run_access(32'h0100_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1 new base ignored");
        run_access(32'h0040_0020, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 old window kept");

        // R2: size code clamp, codes above 4 give 2 MB.
        do_reset(32'h0020_0000, 3'd7);
        run_access(32'h003F_FFFC, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2 clamp top");
        run_access(32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 clamp past");
        run_access(32'h001F_FFFC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 below base");

        // R2: smallest window, code 0 gives 128 KB.
        do_reset(32'h0080_0000, 3'd0);
        run_access(32'h0081_FFF0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2 code0 top");
        run_access(32'h0082_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R2 code0 past");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule